// File: doc/BRIEF.md
# Board Interrupt Aggregator and Control Registers

This block sits on a simple synchronous register port of a 32-bit bus. It gathers sixteen external interrupt lines into a sticky pending register and gates them with an enable register. It raises one combined interrupt toward the host whenever an enabled bit is pending. Software owns the pending register outright: a write to it loads the new value, which both sets and clears bits.

The same address window holds eight plain 32-bit scratch registers, used for LED data, LED control, switch state and miscellaneous control. It also holds two card-slot status words. In each slot word, one bit reports card absence and follows a chosen interrupt line: line 9 for slot 0 and line 13 for slot 1. Software can change only the five lowest bits of a slot word.

There is no sequencing state machine. Every register moves on each clock from its decoded write and the synchronized interrupt levels. Reads return their data one cycle after the read strobe.

Top module: `brd_irq_agg`

## Requirements
- R1: After reset, both slot words (offsets 0xE0, 0xE4) read 0x00000420, with ready at bit 10 and card-absent at bit 5. Every other register reads zero, and `irq_out` is low.
- R2: An interrupt line latches its pending bit only if the line is high after its two-stage synchronizer while the enable bit is already 1. A line raised and dropped while disabled leaves no pending bit, even if it is enabled later.
- R3: A pending bit stays set after its line drops, until software writes the pending register.
- R4: A write to the pending register (offset 0xD0) loads `wr_data & 0x000FEEFF`. In the same cycle, any enabled high line is ORed in, so a hardware event is never lost to a write.
- R5: A write to the enable register (offset 0xC0) stores `wr_data & 0x000FEEFF`. Bits 8, 12 and 20 to 31 always read zero.
- R6: `irq_out` is registered and equals the OR of (pending AND enable). It changes on the same clock edge that updates either register, so it rises three edges after an enabled line rises.
- R7: Bit 5 of the slot 0 word is the inverse of synchronized line 9. Bit 5 of the slot 1 word is the inverse of synchronized line 13. Bit 10 of both words always reads 1.
- R8: A write to a slot word changes only bits [4:0]. Bits 5, 10 and all others keep their values.
- R9: The scratch offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store and return a full 32-bit value.
- R10: A read from any other offset returns zero, and a write to one changes no register.
- R11: `rd_data` holds the addressed value in the cycle after `rd_en` is sampled high, and is zero after a cycle in which `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_in | input | 16 | External interrupt levels, asynchronous |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The assertions assume that `rst_n` is held low for at least one clock. They also assume that a pending bit can fall only through a pending-register write. Interrupt inputs are taken as asynchronous levels. The bench changes them only on falling clock edges and holds each level for at least three rising edges, so the synchronizer output settles before any value is checked. Register accesses are one cycle each, with `rd_en` and `wr_en` never asserted together. The bench sweeps every line and every byte offset against values it computes from the offset list and the reserved-bit mask.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
    localparam int OFF_ENABLE  = 'hC0;
    localparam int OFF_PENDING = 'hD0;
    localparam int OFF_SLOT0   = 'hE0;
    localparam int OFF_SLOT1   = 'hE4;
    localparam int NUM_SCR     = 8;
    localparam logic [31:0] KEEP_MASK = 32'h000F_EEFF;
    localparam int SLOT_WR_BITS = 5;
    localparam int SLOT_CD_BIT  = 5;
    localparam int SLOT_RDY_BIT = 10;

    // byte offset of scratch register i
    function automatic int scr_off(input int i);
        case (i)
            0:       return 'h10;
            1:       return 'h14;
            2:       return 'h40;
            3:       return 'h60;
            4:       return 'h80;
            5:       return 'h84;
            6:       return 'h88;
            default: return 'h90;
        endcase
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                sync_q <= meta_q;
            end
        end
        assign sync_out[g] = sync_q;
    end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int          NUM_IRQ = 16,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] MASK    = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IRQ-1:0] lvl,
    input  logic              en_we,
    input  logic              pend_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] pend_q,
    output logic              irq_out
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(MASK);

    logic [DATA_W-1:0] hw_set, en_d, pend_d;

    always_comb begin
        hw_set = {{(DATA_W-NUM_IRQ){1'b0}}, lvl} & en_q;
        en_d   = en_we ? (wdata & KEEP) : en_q;
        pend_d = (pend_we ? (wdata & KEEP) : pend_q) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            irq_out <= 1'b0;
        end else begin
            en_q    <= en_d;
            pend_q  <= pend_d;
            irq_out <= |(pend_d & en_d);
        end
    end
endmodule

// File: rtl/slot_stat.sv
module slot_stat
    import brd_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [SLOT_WR_BITS-1:0] wdata,
    input  logic                    present,
    output logic [DATA_W-1:0]       stat
);
    logic [SLOT_WR_BITS-1:0] ctl_q;
    logic                    absent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            absent_q <= 1'b1;
        end else begin
            if (we) ctl_q <= wdata;
            absent_q <= ~present;
        end
    end

    always_comb begin
        stat                        = '0;
        stat[SLOT_WR_BITS-1:0]      = ctl_q;
        stat[SLOT_CD_BIT]           = absent_q;
        stat[SLOT_RDY_BIT]          = 1'b1;
    end
endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg
    import brd_irq_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int CD0_IRQ = 9,
    parameter int CD1_IRQ = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic               irq_out
);
    logic [NUM_IRQ-1:0] lvl;
    logic [DATA_W-1:0]  en_q, pend_q, slot0_stat, slot1_stat, rd_mux;
    logic [DATA_W-1:0]  scr_q [NUM_SCR];
    logic [NUM_SCR-1:0] scr_hit;
    logic               en_hit, pend_hit, slot0_hit, slot1_hit;
    logic               en_we, pend_we, slot0_we, slot1_we;

    assign en_hit    = (addr == ADDR_W'(OFF_ENABLE));
    assign pend_hit  = (addr == ADDR_W'(OFF_PENDING));
    assign slot0_hit = (addr == ADDR_W'(OFF_SLOT0));
    assign slot1_hit = (addr == ADDR_W'(OFF_SLOT1));
    assign en_we     = wr_en && en_hit;
    assign pend_we   = wr_en && pend_hit;
    assign slot0_we  = wr_en && slot0_hit;
    assign slot1_we  = wr_en && slot1_hit;

    irq_sync #(.W(NUM_IRQ)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(lvl)
    );

    irq_pend #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .MASK(KEEP_MASK)) u_pend (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .en_we(en_we), .pend_we(pend_we),
        .wdata(wr_data), .en_q(en_q), .pend_q(pend_q), .irq_out(irq_out)
    );

    slot_stat #(.DATA_W(DATA_W)) u_slot0 (
        .clk(clk), .rst_n(rst_n), .we(slot0_we), .wdata(wr_data[SLOT_WR_BITS-1:0]),
        .present(lvl[CD0_IRQ]), .stat(slot0_stat)
    );

    slot_stat #(.DATA_W(DATA_W)) u_slot1 (
        .clk(clk), .rst_n(rst_n), .we(slot1_we), .wdata(wr_data[SLOT_WR_BITS-1:0]),
        .present(lvl[CD1_IRQ]), .stat(slot1_stat)
    );

    for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
        assign scr_hit[g] = (addr == ADDR_W'(scr_off(g)));
        always_ff @(posedge clk) begin
            if (!rst_n)                  scr_q[g] <= '0;
            else if (wr_en && scr_hit[g]) scr_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SCR; i++)
            if (scr_hit[i]) rd_mux = scr_q[i];
        if (en_hit)    rd_mux = en_q;
        if (pend_hit)  rd_mux = pend_q;
        if (slot0_hit) rd_mux = slot0_stat;
        if (slot1_hit) rd_mux = slot1_stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? rd_mux : '0;
    end
endmodule

// File: rtl/brd_irq_agg_chk.sv
module brd_irq_agg_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_out,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] pend_q,
    input logic              pend_we,
    input logic              slot0_we,
    input logic [DATA_W-1:0] slot0_stat
);
    // R2: a bit newly set without a software write must have been enabled
    p_latch_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R3: pending bits fall only through a software write
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6: output tracks masked pending state
    p_out_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(pend_q & en_q)));

    // R8: low slot bits move only on a slot write
    p_slot_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_we |=> $stable(slot0_stat[4:0]));

    // R11: idle read port returns zero
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

bind brd_irq_agg brd_irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .irq_out(irq_out), .en_q(en_q), .pend_q(pend_q), .pend_we(pend_we),
    .slot0_we(slot0_we), .slot0_stat(slot0_stat)
);

// File: tb/brd_irq_agg_bench.sv
module brd_irq_agg_bench;
    localparam logic [31:0] MSK  = 32'h000F_EEFF;
    localparam logic [31:0] SLOT = 32'h0000_0420;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0, rd_data, got;
    logic [15:0] irq_in = '0;
    logic        irq_out;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    brd_irq_agg u_brd_irq_agg (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic int scr_at(input int i);
        case (i)
            0: return 'h10; 1: return 'h14; 2: return 'h40; 3: return 'h60;
            4: return 'h80; 5: return 'h84; 6: return 'h88; default: return 'h90;
        endcase
    endfunction

    function automatic bit mapped(input int a);
        for (int i = 0; i < 8; i++) if (a == scr_at(i)) return 1;
        return (a == 'hC0) || (a == 'hD0) || (a == 'hE0) || (a == 'hE4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); addr = 8'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); addr = 8'(a); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic drive_irq(input logic [15:0] v);
        @(negedge clk); irq_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        for (int a = 0; a < 256; a += 4) begin
            rd(a, got);
            chk("R1 reset", got, (a == 'hE0 || a == 'hE4) ? SLOT : 32'h0);
        end
        // R11 idle read port
        @(negedge clk);
        chk("R11 idle", rd_data, 32'h0);

        // R9 scratch registers
        for (int i = 0; i < 8; i++) wr(scr_at(i), 32'hA500_0000 ^ (32'(scr_at(i)) * 32'h0101_0101));
        for (int i = 0; i < 8; i++) begin
            rd(scr_at(i), got);
            chk("R9 scratch", got, 32'hA500_0000 ^ (32'(scr_at(i)) * 32'h0101_0101));
        end

        // R10 unmapped writes and reads
        for (int a = 0; a < 256; a++) if (!mapped(a)) wr(a, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            rd(scr_at(i), got);
            chk("R10 scratch kept", got, 32'hA500_0000 ^ (32'(scr_at(i)) * 32'h0101_0101));
        end
        rd('hC0, got); chk("R10 enable kept", got, 32'h0);
        rd('hD0, got); chk("R10 pending kept", got, 32'h0);
        rd('hE0, got); chk("R10 slot0 kept", got, SLOT);
        rd('hE4, got); chk("R10 slot1 kept", got, SLOT);
        for (int a = 0; a < 256; a += 4) if (!mapped(a)) begin
            rd(a, got); chk("R10 unmapped read", got, 32'h0);
        end

        // R5 enable mask
        wr('hC0, 32'hFFFF_FFFF);
        rd('hC0, got); chk("R5 enable mask", got, MSK);

        // R2 R3 R6 sweep over every line
        for (int i = 0; i < 16; i++) begin
            wr('hD0, 32'h0);
            drive_irq(16'(1) << i);
            chk("R6 irq_out on", {31'b0, irq_out}, {31'b0, MSK[i]});
            drive_irq(16'h0);
            rd('hD0, got);
            chk("R3 sticky pending", got, (32'(1) << i) & MSK);
            chk("R6 irq_out held", {31'b0, irq_out}, {31'b0, MSK[i]});
        end

        // R2 disabled line leaves nothing
        wr('hC0, 32'h0);
        wr('hD0, 32'h0);
        drive_irq(16'h0008);
        drive_irq(16'h0000);
        wr('hC0, 32'hFFFF_FFFF);
        rd('hD0, got); chk("R2 disabled no latch", got, 32'h0);
        chk("R2 irq_out low", {31'b0, irq_out}, 32'h0);

        // R4 direct load and same-cycle merge
        wr('hC0, 32'h0);
        wr('hD0, 32'hFFFF_FFFF);
        rd('hD0, got); chk("R4 load mask", got, MSK);
        wr('hD0, 32'h0);
        rd('hD0, got); chk("R4 clear", got, 32'h0);
        wr('hC0, 32'h20);
        drive_irq(16'h0020);
        wr('hD0, 32'h0);
        rd('hD0, got); chk("R4 merge", got, 32'h20);
        drive_irq(16'h0000);
        wr('hD0, 32'h0);
        rd('hD0, got); chk("R4 cleared after drop", got, 32'h0);

        // R6 mask change re-evaluates at once
        wr('hC0, 32'h0);
        wr('hD0, 32'h0000_0020);
        chk("R6 masked off", {31'b0, irq_out}, 32'h0);
        wr('hC0, 32'h0000_0020);
        chk("R6 enable raises", {31'b0, irq_out}, 32'h1);
        wr('hC0, 32'h0);
        chk("R6 enable drops", {31'b0, irq_out}, 32'h0);

        // R7 card detect
        drive_irq(16'h0200);
        rd('hE0, got); chk("R7 slot0 present", got, 32'h400);
        rd('hE4, got); chk("R7 slot1 idle", got, SLOT);
        drive_irq(16'h2000);
        rd('hE0, got); chk("R7 slot0 absent", got, SLOT);
        rd('hE4, got); chk("R7 slot1 present", got, 32'h400);
        drive_irq(16'h0000);
        rd('hE4, got); chk("R7 slot1 absent", got, SLOT);

        // R8 partial slot writes
        wr('hE0, 32'hFFFF_FFFF);
        rd('hE0, got); chk("R8 slot0 low bits", got, 32'h43F);
        drive_irq(16'h0200);
        rd('hE0, got); chk("R8 slot0 with card", got, 32'h41F);
        wr('hE4, 32'h0000_0015);
        rd('hE4, got); chk("R8 slot1 low bits", got, 32'h435);
        wr('hE0, 32'h0);
        drive_irq(16'h0000);
        rd('hE0, got); chk("R8 slot0 cleared", got, SLOT);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule